// File: doc/BRIEF.md
# SDRAM Refresh Sequencer with User-Driven Bursts

This block owns the SDRAM command bus for refresh. A read/write scheduler reaches the bus through it, using a grant output, a busy input and a one-cycle-delayed pass-through of its command. Refresh has priority over new scheduler traffic, but a burst that is already running is allowed to finish. The block then closes every bank with one precharge-all command and issues auto-refresh commands. It pulses an acknowledge for each auto-refresh.

The source of the refresh trigger is chosen by an input. In user mode, a held request input starts the sequence. If the request is still high when the refresh recovery time ends, another auto-refresh follows at once, so refreshes can be grouped into idle periods. In timer mode, an interval counter raises the trigger and the request input is ignored. The acknowledge pulses in both modes. Minimum precharge-to-refresh and refresh-to-refresh spacings are parameters, and NOP cycles fill the gaps.

Top module: `sdram_rfsh_seq`

## Requirements
- R1: While the selected trigger is high and the block is idle, `sched_grant` is low, and it stays low for the whole refresh sequence.
- R2: While `sched_busy` is high the block does not start refreshing: outputs keep passing the scheduler command through. The precharge-all appears on the first clock edge at which the trigger is high and `sched_busy` is low.
- R3: The precharge-all drives chip select all zeros, RAS/CAS/WE = 0/1/0, address 0x0400 (only bit 10 set) and bank 0.
- R4: Each auto-refresh drives chip select all zeros, RAS/CAS/WE = 0/0/1, address 0 and bank 0. The first one appears exactly `T_RP` cycles after the precharge-all. `refresh_ack` is high in exactly the cycles that carry an auto-refresh.
- R5: If the trigger is high `T_RFC` cycles after an auto-refresh, the next auto-refresh is issued in that cycle with no new precharge.
- R6: If the trigger is low `T_RFC` cycles after an auto-refresh, that cycle carries a NOP and `sched_grant` returns high.
- R7: When `user_mode` is low, `refresh_req` has no effect. A refresh sequence starts `REF_INTERVAL` cycles after the previous auto-refresh, and its auto-refresh is acknowledged. When `user_mode` is high, the interval counter never starts a refresh.
- R8: Every non-command cycle inside a refresh sequence is a NOP: chip select all ones, RAS/CAS/WE = 1/1/1, address 0, bank 0.
- R9: While `rst` is high, outputs show a NOP with chip select all ones, `refresh_ack` stays low, and `mem_cke` is high.
- R10: While idle and not refreshing, the outputs carry the scheduler's chip select, RAS/CAS/WE, address and bank one cycle after they are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| user_mode | input | 1 | 1: refresh on request; 0: refresh on internal interval |
| refresh_req | input | 1 | User refresh request, held for a burst of refreshes |
| refresh_ack | output | 1 | One-cycle pulse with each auto-refresh command |
| sched_busy | input | 1 | Scheduler has a burst in progress |
| sched_grant | output | 1 | Scheduler may start new commands |
| sched_cs_n | input | RANKS | Scheduler chip selects |
| sched_ras_n | input | 1 | Scheduler RAS |
| sched_cas_n | input | 1 | Scheduler CAS |
| sched_we_n | input | 1 | Scheduler WE |
| sched_addr | input | ADDR_W | Scheduler address |
| sched_ba | input | BA_W | Scheduler bank address |
| mem_cs_n | output | RANKS | Memory chip selects |
| mem_cke | output | 1 | Memory clock enable, always high |
| mem_ras_n | output | 1 | Memory RAS |
| mem_cas_n | output | 1 | Memory CAS |
| mem_we_n | output | 1 | Memory WE |
| mem_addr | output | ADDR_W | Memory address |
| mem_ba | output | BA_W | Memory bank address |

## Verification
The assertions assume that the scheduler keeps `sched_busy` high for its whole burst and that `REF_INTERVAL` is larger than `T_RFC`, so a timer-started sequence never chains. Stimulus changes inputs only on falling edges. `sched_busy` is released only after a chosen number of pass-through cycles. The scheduler inputs hold one fixed read pattern throughout, including during refresh, so any leak of scheduler commands onto the bus during a sequence shows up at the outputs. The request is dropped on the falling edge after the last wanted acknowledge, so each chained decision sees a stable level.

// File: rtl/sdram_rfsh_pkg.sv
package sdram_rfsh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PCH_GAP = 2'd1,
    ST_REF_GAP = 2'd2
  } rfsh_state_t;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP  = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_PCH  = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam sd_cmd_t CMD_AREF = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/sdram_rfsh_interval.sv
// Counts cycles since the last auto-refresh; saturates at the due point.
module sdram_rfsh_interval #(
  parameter int unsigned REF_INTERVAL = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic due
);
  localparam int unsigned CW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(REF_INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  assign due = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (!due) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_TIMER_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clear |=> !due); // R7

endmodule

// File: rtl/sdram_rfsh_gap.sv
// Down-counter that enforces the precharge and refresh recovery spacings.
module sdram_rfsh_gap #(
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RFC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load_rp,
  input  logic load_rfc,
  output logic done
);
  localparam int unsigned T_MAX = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int unsigned CW    = $clog2(T_MAX + 1);
  localparam logic [CW-1:0] RP_LOAD  = CW'(T_RP - 1);
  localparam logic [CW-1:0] RFC_LOAD = CW'(T_RFC - 1);

  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_rp) begin
      cnt_q <= RP_LOAD;
    end else if (load_rfc) begin
      cnt_q <= RFC_LOAD;
    end else if (!done) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
    !(load_rp && load_rfc)); // R4

  AST_LOAD_ONLY_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    load_rfc |-> done); // R5

endmodule

// File: rtl/sdram_rfsh_seq.sv
module sdram_rfsh_seq #(
  parameter int unsigned RANKS        = 2,
  parameter int unsigned ADDR_W       = 13,
  parameter int unsigned BA_W         = 2,
  parameter int unsigned T_RP         = 3,
  parameter int unsigned T_RFC        = 8,
  parameter int unsigned REF_INTERVAL = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              user_mode,
  input  logic              refresh_req,
  output logic              refresh_ack,
  input  logic              sched_busy,
  output logic              sched_grant,
  input  logic [RANKS-1:0]  sched_cs_n,
  input  logic              sched_ras_n,
  input  logic              sched_cas_n,
  input  logic              sched_we_n,
  input  logic [ADDR_W-1:0] sched_addr,
  input  logic [BA_W-1:0]   sched_ba,
  output logic [RANKS-1:0]  mem_cs_n,
  output logic              mem_cke,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BA_W-1:0]   mem_ba
);
  import sdram_rfsh_pkg::*;

  localparam logic [ADDR_W-1:0] ALL_BANKS = {{(ADDR_W-1){1'b0}}, 1'b1} << 10;

  rfsh_state_t       st_q;
  sd_cmd_t           cmd_q;
  logic [RANKS-1:0]  cs_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BA_W-1:0]   ba_q;
  logic              ack_q;

  logic trig;
  logic timer_due;
  logic gap_done;
  logic start_pch;
  logic issue_ref;

  // Trigger source: user request or internal interval, never both.
  assign trig = user_mode ? refresh_req : timer_due;

  assign start_pch = (st_q == ST_IDLE) && trig && !sched_busy;
  assign issue_ref = gap_done &&
                     ((st_q == ST_PCH_GAP) || ((st_q == ST_REF_GAP) && trig));

  // Grant drops in the same cycle the trigger rises, so no new command starts.
  assign sched_grant = (st_q == ST_IDLE) && !trig;

  sdram_rfsh_interval #(
    .REF_INTERVAL(REF_INTERVAL)
  ) u_interval (
    .clk   (clk),
    .rst   (rst),
    .clear (issue_ref),
    .due   (timer_due)
  );

  sdram_rfsh_gap #(
    .T_RP (T_RP),
    .T_RFC(T_RFC)
  ) u_gap (
    .clk     (clk),
    .rst     (rst),
    .load_rp (start_pch),
    .load_rfc(issue_ref),
    .done    (gap_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cmd_q  <= CMD_NOP;
      cs_q   <= '1;
      addr_q <= '0;
      ba_q   <= '0;
      ack_q  <= 1'b0;
    end else begin
      ack_q  <= 1'b0;
      cmd_q  <= CMD_NOP;
      cs_q   <= '1;
      addr_q <= '0;
      ba_q   <= '0;
      case (st_q)
        ST_IDLE: begin
          if (start_pch) begin
            cmd_q  <= CMD_PCH;
            cs_q   <= '0;
            addr_q <= ALL_BANKS;
            st_q   <= ST_PCH_GAP;
          end else begin
            cmd_q  <= '{ras_n: sched_ras_n, cas_n: sched_cas_n, we_n: sched_we_n};
            cs_q   <= sched_cs_n;
            addr_q <= sched_addr;
            ba_q   <= sched_ba;
          end
        end
        ST_PCH_GAP: begin
          if (issue_ref) begin
            cmd_q <= CMD_AREF;
            cs_q  <= '0;
            ack_q <= 1'b1;
            st_q  <= ST_REF_GAP;
          end
        end
        ST_REF_GAP: begin
          if (issue_ref) begin
            cmd_q <= CMD_AREF;
            cs_q  <= '0;
            ack_q <= 1'b1;
          end else if (gap_done) begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_cke     = 1'b1;
  assign mem_cs_n    = cs_q;
  assign mem_ras_n   = cmd_q.ras_n;
  assign mem_cas_n   = cmd_q.cas_n;
  assign mem_we_n    = cmd_q.we_n;
  assign mem_addr    = addr_q;
  assign mem_ba      = ba_q;
  assign refresh_ack = ack_q;

  AST_BURST_FINISHES: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && sched_busy) |=> (st_q == ST_IDLE)); // R2

  AST_PCH_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PCH_GAP && $past(st_q) == ST_IDLE) |->
      (mem_addr == ALL_BANKS && mem_cs_n == '0 && !mem_ras_n && mem_cas_n && !mem_we_n)); // R3

  AST_ACK_ON_REF: assert property (@(posedge clk) disable iff (rst)
    refresh_ack |-> (mem_cs_n == '0 && !mem_ras_n && !mem_cas_n && mem_we_n)); // R4

  AST_NO_SECOND_PCH: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |->
      !(!mem_ras_n && mem_cas_n && !mem_we_n)); // R5

  AST_NOP_DESELECTS: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE && mem_ras_n && mem_cas_n && mem_we_n) |-> (mem_cs_n == '1)); // R8

  AST_GRANT_OFF_IN_SEQ: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |-> !sched_grant); // R1

endmodule

// File: tb/test_sdram_rfsh_seq.sv
module test_sdram_rfsh_seq;
  localparam int RANKS = 2;
  localparam int ADDR_W = 13;
  localparam int BA_W = 2;
  localparam int T_RP = 2;
  localparam int T_RFC = 4;
  localparam int REF_INTERVAL = 40;

  localparam int K_NOP = 0;
  localparam int K_PCH = 1;
  localparam int K_REF = 2;
  localparam int K_PASS = 3;

  localparam logic [RANKS-1:0]  S_CS   = 2'b10;
  localparam logic [ADDR_W-1:0] S_ADDR = 13'h0123;
  localparam logic [BA_W-1:0]   S_BA   = 2'b01;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic user_mode = 1'b1;
  logic refresh_req = 1'b0;
  logic sched_busy = 1'b0;
  logic refresh_ack, sched_grant, mem_cke, mem_ras_n, mem_cas_n, mem_we_n;
  logic [RANKS-1:0] mem_cs_n;
  logic [ADDR_W-1:0] mem_addr;
  logic [BA_W-1:0] mem_ba;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdram_rfsh_seq #(
    .RANKS(RANKS), .ADDR_W(ADDR_W), .BA_W(BA_W),
    .T_RP(T_RP), .T_RFC(T_RFC), .REF_INTERVAL(REF_INTERVAL)
  ) i_sdram_rfsh_seq (
    .clk(clk), .rst(rst), .user_mode(user_mode),
    .refresh_req(refresh_req), .refresh_ack(refresh_ack),
    .sched_busy(sched_busy), .sched_grant(sched_grant),
    .sched_cs_n(S_CS), .sched_ras_n(1'b1), .sched_cas_n(1'b0), .sched_we_n(1'b1),
    .sched_addr(S_ADDR), .sched_ba(S_BA),
    .mem_cs_n(mem_cs_n), .mem_cke(mem_cke), .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_ba(mem_ba)
  );

  function automatic logic [31:0] expv(int kind);
    logic [RANKS-1:0] cs;
    logic [2:0] c;
    logic [ADDR_W-1:0] a;
    logic [BA_W-1:0] b;
    logic k;
    cs = '1; c = 3'b111; a = '0; b = '0; k = 1'b0;
    case (kind)
      K_PCH:  begin cs = '0; c = 3'b010; a = ADDR_W'(1) << 10; end
      K_REF:  begin cs = '0; c = 3'b001; k = 1'b1; end
      K_PASS: begin cs = S_CS; c = 3'b101; a = S_ADDR; b = S_BA; end
      default: ;
    endcase
    return 32'({cs, c, a, b, k});
  endfunction

  function automatic logic [31:0] actv();
    return 32'({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_addr, mem_ba, refresh_ack});
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_cmd(input string req, input string what, input int kind);
    chk(actv() == expv(kind), req, what, actv(), expv(kind));
  endtask

  // One user-driven refresh burst of nref refreshes after nb busy cycles.
  task automatic user_burst(input int nref, input int nb);
    int refs;
    int t_end;
    @(negedge clk);
    refresh_req = 1'b1;
    sched_busy = (nb > 0);
    #1 chk(sched_grant == 1'b0, "R1", "grant on request", 32'(sched_grant), 0);
    for (int i = 1; i <= nb; i++) begin
      @(negedge clk);
      chk_cmd("R2", "pass-through while busy", K_PASS);
      chk(sched_grant == 1'b0, "R1", "grant while busy", 32'(sched_grant), 0);
      if (i == nb) sched_busy = 1'b0;
    end
    refs = 0;
    t_end = 1 + T_RP + nref * T_RFC;
    for (int t = 1; t <= t_end; t++) begin
      @(negedge clk);
      if (t == 1) begin
        chk_cmd("R3", "precharge-all", K_PCH);
      end else if (t >= 1 + T_RP && ((t - 1 - T_RP) % T_RFC) == 0 && refs < nref) begin
        if (refs == 0) chk_cmd("R4", "first refresh", K_REF);
        else chk_cmd("R5", "chained refresh", K_REF);
        refs++;
        if (refs == nref) refresh_req = 1'b0;
      end else if (t == t_end) begin
        chk_cmd("R6", "release NOP", K_NOP);
      end else begin
        chk_cmd("R8", "gap NOP", K_NOP);
      end
      if (t < t_end)
        chk(sched_grant == 1'b0, "R1", "grant in sequence", 32'(sched_grant), 0);
      else
        chk(sched_grant == 1'b1, "R6", "grant returned", 32'(sched_grant), 1);
    end
    @(negedge clk);
    chk_cmd("R10", "pass-through after release", K_PASS);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int waited;
    repeat (3) @(negedge clk);
    chk_cmd("R9", "reset outputs", K_NOP);
    chk(mem_cke == 1'b1, "R9", "cke in reset", 32'(mem_cke), 1);
    rst = 1'b0;
    @(negedge clk);
    chk_cmd("R10", "pass-through", K_PASS);
    chk(sched_grant == 1'b1, "R10", "grant idle", 32'(sched_grant), 1);

    for (int nb = 0; nb <= 3; nb++) begin
      for (int nref = 1; nref <= 4; nref++) begin
        user_burst(nref, nb);
      end
    end

    // User mode: the interval counter must never start a refresh.
    for (int i = 0; i < 3 * REF_INTERVAL; i++) begin
      @(negedge clk);
      chk_cmd("R7", "timer ignored in user mode", K_PASS);
    end

    // Timer mode: request held high must be ignored.
    user_mode = 1'b0;
    refresh_req = 1'b1;
    waited = 0;
    while (refresh_ack !== 1'b1 && waited < 3 * REF_INTERVAL) begin
      @(negedge clk);
      waited++;
    end
    chk(refresh_ack == 1'b1, "R7", "timer refresh ack", 32'(refresh_ack), 1);
    for (int j = 1; j <= REF_INTERVAL + T_RP; j++) begin
      @(negedge clk);
      if (j <= T_RFC) chk_cmd("R7", "no chaining in timer mode", K_NOP);
      else if (j < REF_INTERVAL) chk_cmd("R7", "idle between timer refreshes", K_PASS);
      else if (j == REF_INTERVAL) chk_cmd("R7", "timer precharge", K_PCH);
      else if (j < REF_INTERVAL + T_RP) chk_cmd("R7", "timer gap", K_NOP);
      else chk_cmd("R7", "timer refresh", K_REF);
    end
    refresh_req = 1'b0;
    user_mode = 1'b1;
    repeat (T_RFC + 2) @(negedge clk);
    chk_cmd("R10", "pass-through after timer", K_PASS);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule